// File: doc/BRIEF.md
# SMT Issue-Queue Slot Allocator

This block does the admission accounting for a shared issue queue in a multithreaded core. It does not store instructions. It keeps one occupancy counter per hardware thread and one global free-slot counter. From these it reports, for every thread, how many more slots that thread may claim, and whether the thread or the whole queue is full. A front end asks for a slot with a thread-tagged insert strobe. The back end gives a slot back with a thread-tagged release strobe, used when a non-memory op issues or a memory op completes. A thread-tagged squash strobe also gives back one slot.

Each thread's ceiling is held in a limit register. A sharing policy fills these registers. The shared policy gives every thread the whole queue. The even-split policy divides the queue by the configured thread count. The percentage policy caps each thread at a fraction of the queue. When software changes the set of active threads, the limits are refreshed with that set.

Top module: `iqa_alloc_top`

## Requirements
- R1: After reset every thread has zero occupancy and a limit of QUEUE_DEPTH. Each thread free count reads QUEUE_DEPTH, `glob_free` reads QUEUE_DEPTH, and no full flag is set.
- R2: A `cfg_load` pulse with `policy_sel` = 0 (shared) sets every thread limit to QUEUE_DEPTH. Code 3 behaves the same as code 0.
- R3: A `cfg_load` pulse with `policy_sel` = 1 (even split) sets every thread limit to QUEUE_DEPTH / NUM_THREADS, rounded down.
- R4: A `cfg_load` pulse with `policy_sel` = 2 (percentage) sets every limit to floor(p * QUEUE_DEPTH / 100). Here p is `thresh_pct`, and any value above 100 is used as 100.
- R5: An `act_upd` pulse under policy 1 sets the limit of every thread whose `active_mask` bit is 1 to QUEUE_DEPTH / (number of set mask bits), rounded down. Inactive threads keep their limits. An all-zero mask changes nothing.
- R6: An `act_upd` pulse under policy 2 with exactly one mask bit set gives that thread a limit of QUEUE_DEPTH. Any other mask under policy 2, and any mask under policies 0 and 3, leaves every limit unchanged.
- R7: A thread's free count is its limit minus its occupancy, or 0 when the occupancy is not below the limit. Its full flag is 1 exactly when that count is 0.
- R8: An insert to a thread that is not full, while the queue is not globally full, raises that thread's occupancy by one and lowers `glob_free` by one. Both show in the outputs one clock after the strobe.
- R9: An insert is dropped with no effect on any output when its thread is full or when `glob_full` is set.
- R10: A release or a squash strobe each lower the tagged thread's occupancy by one and raise `glob_free` by one. A strobe that finds no occupancy left is ignored. When both strobes hit the same thread with one entry, only one entry is returned.
- R11: `glob_full` is 1 exactly when `glob_free` is 0. `glob_free` always equals QUEUE_DEPTH minus the sum of all thread occupancies.
- R12: When `cfg_load` and `act_upd` arrive in the same cycle, the policy value is applied first. The active-set rule then overrides it for the threads the rule touches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_sel | input | 2 | Sharing policy: 0 shared, 1 even split, 2 percentage, 3 shared |
| thresh_pct | input | PCT_W | Percentage cap used by policy 2 |
| cfg_load | input | 1 | Reload every limit from the policy |
| active_mask | input | NUM_THREADS | Active-thread set, one bit per thread |
| act_upd | input | 1 | Refresh limits from the active-thread set |
| alloc_vld | input | 1 | Insert strobe |
| alloc_tid | input | TW | Thread of the insert |
| free_vld | input | 1 | Release strobe (issue or memory completion) |
| free_tid | input | TW | Thread of the release |
| squash_vld | input | 1 | Squash strobe, returns one entry |
| squash_tid | input | TW | Thread of the squash |
| thr_free | output | NUM_THREADS*CW | Per-thread free counts, thread i at bits [i*CW +: CW] |
| thr_full | output | NUM_THREADS | Per-thread full flags |
| glob_free | output | CW | Global free-slot count |
| glob_full | output | 1 | Queue full |

## Verification
All state sits in registers: the limits, the occupancies and the global counter. A strobe or configuration pulse sampled at one rising edge therefore shows in every output after that same edge, one cycle later. The outputs are combinational decodes of that state, so nothing takes longer. The bench drives inputs on the falling edge and updates its behavioural model at the rising edge. It compares every output at the next falling edge, so each result is sampled exactly in the cycle it is due. Boundary cases are placed directly: a limit that drops below the current occupancy, a full queue, strobes on an empty thread, and colliding configuration pulses.

// File: rtl/iqa_pkg.sv
package iqa_pkg;
   typedef enum logic [1:0] {
      POL_SHARED = 2'd0,
      POL_SPLIT  = 2'd1,
      POL_PCT    = 2'd2,
      POL_RSVD   = 2'd3
   } iqa_policy_e;
endpackage

// File: rtl/iqa_limit_calc.sv
module iqa_limit_calc
   import iqa_pkg::*;
#(
   parameter int NT    = 4,
   parameter int DEPTH = 32,
   parameter int CW    = 6,
   parameter int PW    = 7
) (
   input  logic [1:0]       policy,
   input  logic [PW-1:0]    pct,
   input  logic [NT-1:0]    mask,
   input  logic             cfg_load,
   input  logic             act_upd,
   input  logic [NT*CW-1:0] lim_q,
   output logic [NT*CW-1:0] lim_d
);
   localparam int PRODW = PW + CW;
   localparam int AW    = $clog2(NT + 1);

   logic [CW-1:0]    quot [NT+1];
   logic [PW-1:0]    pct_c;
   logic [PRODW-1:0] prod;
   logic [CW-1:0]    pct_lim;
   logic [CW-1:0]    base;
   logic [AW-1:0]    nact;
   iqa_policy_e      pol;

   assign quot[0] = CW'(DEPTH);
   for (genvar k = 1; k <= NT; k++) begin : g_quot
      assign quot[k] = CW'(DEPTH / k);
   end

   always_comb begin
      pol     = iqa_policy_e'(policy);
      pct_c   = (pct > PW'(100)) ? PW'(100) : pct;
      prod    = PRODW'(pct_c) * PRODW'(DEPTH);
      pct_lim = CW'(prod / PRODW'(100));
      case (pol)
         POL_SPLIT: base = quot[NT];
         POL_PCT:   base = pct_lim;
         default:   base = CW'(DEPTH);
      endcase
      nact = '0;
      for (int i = 0; i < NT; i++) nact = nact + AW'(mask[i]);
   end

   always_comb begin
      for (int i = 0; i < NT; i++) begin
         logic [CW-1:0] v;
         v = lim_q[i*CW +: CW];
         if (cfg_load) v = base;
         if (act_upd && mask[i]) begin
            if (pol == POL_SPLIT && nact != '0) v = quot[nact];
            else if (pol == POL_PCT && nact == AW'(1)) v = CW'(DEPTH);
         end
         lim_d[i*CW +: CW] = v;
      end
   end
endmodule

// File: rtl/iqa_thread_ctr.sv
module iqa_thread_ctr #(
   parameter int DEPTH = 32,
   parameter int CW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] lim,
   input  logic          ins_ok,
   input  logic          rel,
   input  logic          sq,
   output logic [CW-1:0] occ,
   output logic [CW-1:0] free_cnt,
   output logic          full,
   output logic [1:0]    ret
);
   logic rel_ok, sq_ok;

   always_comb begin
      rel_ok   = rel && (occ != '0);
      sq_ok    = sq && (occ > CW'(rel_ok));
      ret      = 2'(rel_ok) + 2'(sq_ok);
      free_cnt = (lim > occ) ? (lim - occ) : '0;
      full     = (free_cnt == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) occ <= '0;
      else        occ <= occ + CW'(ins_ok) - CW'(ret);
   end
endmodule

// File: rtl/iqa_global_ctr.sv
module iqa_global_ctr #(
   parameter int DEPTH = 32,
   parameter int CW    = 6,
   parameter int RSW   = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ins_any,
   input  logic [RSW-1:0] ret_sum,
   output logic [CW-1:0]  gfree,
   output logic           gfull
);
   assign gfull = (gfree == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) gfree <= CW'(DEPTH);
      else        gfree <= gfree + CW'(ret_sum) - CW'(ins_any);
   end
endmodule

// File: rtl/iqa_alloc_top.sv
module iqa_alloc_top #(
   parameter int NUM_THREADS = 4,
   parameter int QUEUE_DEPTH = 32,
   parameter int PCT_W       = 7,
   localparam int TW  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
   localparam int CW  = $clog2(QUEUE_DEPTH + 1),
   localparam int RSW = $clog2(2 * NUM_THREADS + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [1:0]                policy_sel,
   input  logic [PCT_W-1:0]          thresh_pct,
   input  logic                      cfg_load,
   input  logic [NUM_THREADS-1:0]    active_mask,
   input  logic                      act_upd,
   input  logic                      alloc_vld,
   input  logic [TW-1:0]             alloc_tid,
   input  logic                      free_vld,
   input  logic [TW-1:0]             free_tid,
   input  logic                      squash_vld,
   input  logic [TW-1:0]             squash_tid,
   output logic [NUM_THREADS*CW-1:0] thr_free,
   output logic [NUM_THREADS-1:0]    thr_full,
   output logic [CW-1:0]             glob_free,
   output logic                      glob_full
);
   if (NUM_THREADS < 1) begin : g_bad_nt
      $error("NUM_THREADS must be at least 1");
   end
   if (QUEUE_DEPTH < 2 * NUM_THREADS) begin : g_bad_depth
      $error("QUEUE_DEPTH must be at least twice NUM_THREADS");
   end
   if (PCT_W < 7) begin : g_bad_pw
      $error("PCT_W must hold the value 100");
   end

   logic [NUM_THREADS*CW-1:0] lim_q, lim_d, occ_flat;
   logic [NUM_THREADS-1:0]    ins_hit;
   logic [1:0]                ret [NUM_THREADS];
   logic [RSW-1:0]            ret_sum;

   iqa_limit_calc #(.NT(NUM_THREADS), .DEPTH(QUEUE_DEPTH), .CW(CW), .PW(PCT_W)) u_lim (
      .policy(policy_sel), .pct(thresh_pct), .mask(active_mask),
      .cfg_load(cfg_load), .act_upd(act_upd), .lim_q(lim_q), .lim_d(lim_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) lim_q <= {NUM_THREADS{CW'(QUEUE_DEPTH)}};
      else        lim_q <= lim_d;
   end

   for (genvar i = 0; i < NUM_THREADS; i++) begin : g_thr
      assign ins_hit[i] = alloc_vld && (alloc_tid == TW'(i)) && !glob_full && !thr_full[i];
      iqa_thread_ctr #(.DEPTH(QUEUE_DEPTH), .CW(CW)) u_ctr (
         .clk(clk), .rst_n(rst_n),
         .lim(lim_q[i*CW +: CW]),
         .ins_ok(ins_hit[i]),
         .rel(free_vld && (free_tid == TW'(i))),
         .sq(squash_vld && (squash_tid == TW'(i))),
         .occ(occ_flat[i*CW +: CW]),
         .free_cnt(thr_free[i*CW +: CW]),
         .full(thr_full[i]),
         .ret(ret[i])
      );
   end

   always_comb begin
      ret_sum = '0;
      for (int i = 0; i < NUM_THREADS; i++) ret_sum = ret_sum + RSW'(ret[i]);
   end

   iqa_global_ctr #(.DEPTH(QUEUE_DEPTH), .CW(CW), .RSW(RSW)) u_glob (
      .clk(clk), .rst_n(rst_n), .ins_any(|ins_hit), .ret_sum(ret_sum),
      .gfree(glob_free), .gfull(glob_full)
   );
endmodule

// File: rtl/iqa_alloc_chk.sv
module iqa_alloc_chk #(
   parameter int NT    = 4,
   parameter int DEPTH = 32,
   parameter int CW    = 6,
   parameter int TW    = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic           alloc_vld,
   input logic [TW-1:0]  alloc_tid,
   input logic           free_vld,
   input logic [TW-1:0]  free_tid,
   input logic           squash_vld,
   input logic [NT-1:0]  thr_full,
   input logic [CW-1:0]  glob_free,
   input logic           glob_full,
   input logic [NT*CW-1:0] occ_flat
);
   int occ_sum;
   always_comb begin
      occ_sum = 0;
      for (int i = 0; i < NT; i++) occ_sum += int'(occ_flat[i*CW +: CW]);
   end

   assert_conserve_R11: assert property (@(posedge clk) disable iff (!rst_n)
      int'(glob_free) + occ_sum == DEPTH);

   assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      int'(glob_free) <= DEPTH);

   assert_drop_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      glob_full && alloc_vld && !free_vld && !squash_vld |=> glob_free == '0);

   assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_vld && (int'(alloc_tid) < NT) && !glob_full && !thr_full[alloc_tid]
      && !free_vld && !squash_vld |=> glob_free == $past(glob_free) - CW'(1));

   assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      free_vld && !alloc_vld && !squash_vld && (int'(free_tid) < NT)
      && occ_flat[free_tid*CW +: CW] != '0 |=> glob_free == $past(glob_free) + CW'(1));
endmodule

bind iqa_alloc_top iqa_alloc_chk #(.NT(NUM_THREADS), .DEPTH(QUEUE_DEPTH), .CW(CW), .TW(TW)) u_chk (
   .clk(clk), .rst_n(rst_n), .alloc_vld(alloc_vld), .alloc_tid(alloc_tid),
   .free_vld(free_vld), .free_tid(free_tid), .squash_vld(squash_vld),
   .thr_full(thr_full), .glob_free(glob_free), .glob_full(glob_full),
   .occ_flat(occ_flat)
);

// File: tb/tb_iqa_alloc_top.sv
module tb_iqa_alloc_top;
   localparam int PERIOD = 10;
   localparam int NT = 4;
   localparam int DEPTH = 32;
   localparam int PW = 7;
   localparam int TW = 2;
   localparam int CW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] policy_sel = 2'd0;
   logic [PW-1:0] thresh_pct = '0;
   logic cfg_load = 1'b0, act_upd = 1'b0;
   logic [NT-1:0] active_mask = '0;
   logic alloc_vld = 1'b0, free_vld = 1'b0, squash_vld = 1'b0;
   logic [TW-1:0] alloc_tid = '0, free_tid = '0, squash_tid = '0;
   logic [NT*CW-1:0] thr_free;
   logic [NT-1:0] thr_full;
   logic [CW-1:0] glob_free;
   logic glob_full;

   int n_cmp = 0, n_bad = 0;
   int lim [NT];
   int occ [NT];
   int gf;

   always #(PERIOD/2) clk = ~clk;

   iqa_alloc_top #(.NUM_THREADS(NT), .QUEUE_DEPTH(DEPTH), .PCT_W(PW)) dut (.*);

   function automatic int tfree(int i);
      return (lim[i] > occ[i]) ? lim[i] - occ[i] : 0;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NT; i++) begin lim[i] = DEPTH; occ[i] = 0; end
      gf = DEPTH;
   endtask

   task automatic model_step();
      int nl [NT];
      int cnt, base, p;
      bit take [NT];
      cnt = 0;
      for (int i = 0; i < NT; i++) cnt += active_mask[i];
      p = (thresh_pct > 100) ? 100 : int'(thresh_pct);
      base = (policy_sel == 2'd1) ? DEPTH / NT : (policy_sel == 2'd2) ? (p * DEPTH) / 100 : DEPTH;
      for (int i = 0; i < NT; i++) begin
         nl[i] = cfg_load ? base : lim[i];
         if (act_upd && active_mask[i]) begin
            if (policy_sel == 2'd1 && cnt > 0) nl[i] = DEPTH / cnt;
            if (policy_sel == 2'd2 && cnt == 1) nl[i] = DEPTH;
         end
      end
      for (int i = 0; i < NT; i++) take[i] = 0;
      if (alloc_vld && gf > 0 && tfree(int'(alloc_tid)) > 0) take[alloc_tid] = 1;
      for (int i = 0; i < NT; i++) begin
         int left;
         left = occ[i];
         if (take[i]) begin occ[i]++; gf--; end
         if (free_vld && int'(free_tid) == i && left > 0) begin occ[i]--; gf++; left--; end
         if (squash_vld && int'(squash_tid) == i && left > 0) begin occ[i]--; gf++; end
      end
      for (int i = 0; i < NT; i++) lim[i] = nl[i];
   endtask

   task automatic chk(string tag, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      for (int i = 0; i < NT; i++) begin
         chk(tag, $sformatf("thr_free[%0d]", i), int'(thr_free[i*CW +: CW]), tfree(i));
         chk(tag, $sformatf("thr_full[%0d]", i), int'(thr_full[i]), int'(tfree(i) == 0));
      end
      chk(tag, "glob_free", int'(glob_free), gf);
      chk(tag, "glob_full", int'(glob_full), int'(gf == 0));
   endtask

   task automatic cyc(string tag);
      @(posedge clk);
      if (rst_n) model_step(); else model_reset();
      @(negedge clk);
      compare(tag);
      alloc_vld = 0; free_vld = 0; squash_vld = 0; cfg_load = 0; act_upd = 0;
   endtask

   task automatic ins(int t, string tag);
      alloc_vld = 1; alloc_tid = TW'(t); cyc(tag);
   endtask
   task automatic rel(int t, string tag);
      free_vld = 1; free_tid = TW'(t); cyc(tag);
   endtask
   task automatic cfg(int pol, int pct, string tag);
      policy_sel = 2'(pol); thresh_pct = PW'(pct); cfg_load = 1; cyc(tag);
   endtask
   task automatic act(logic [NT-1:0] m, string tag);
      active_mask = m; act_upd = 1; cyc(tag);
   endtask

   initial begin
      #(PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      model_reset();
      @(negedge clk); @(negedge clk);
      cyc("R1");
      rst_n = 1;
      cyc("R1");
      for (int k = 0; k < 3; k++) ins(0, "R8");
      rel(0, "R10");
      squash_vld = 1; squash_tid = 0; cyc("R10");
      free_vld = 1; free_tid = 0; squash_vld = 1; squash_tid = 0; cyc("R10");
      rel(0, "R10");
      squash_vld = 1; squash_tid = 2; cyc("R10");
      cfg(1, 0, "R3");
      for (int k = 0; k < 10; k++) ins(1, "R7");
      ins(1, "R9");
      cfg(2, 25, "R4");
      cfg(2, 50, "R4");
      cfg(2, 33, "R4");
      cfg(2, 120, "R4");
      cfg(1, 0, "R3");
      act(4'b0011, "R5");
      act(4'b0111, "R5");
      act(4'b0000, "R5");
      cfg(2, 10, "R4");
      act(4'b0100, "R6");
      act(4'b0110, "R6");
      policy_sel = 2'd0; act(4'b0001, "R6");
      cfg(3, 0, "R2");
      cfg(0, 0, "R2");
      for (int k = 0; k < 40; k++) ins(k % NT, "R11");
      ins(2, "R9");
      alloc_vld = 1; alloc_tid = 3; free_vld = 1; free_tid = 0; cyc("R11");
      cfg(1, 0, "R7");
      policy_sel = 2'd1; thresh_pct = 0; cfg_load = 1; active_mask = 4'b1000; act_upd = 1; cyc("R12");
      policy_sel = 2'd2; thresh_pct = 20; cfg_load = 1; active_mask = 4'b0010; act_upd = 1; cyc("R12");
      for (int k = 0; k < 600; k++) begin
         alloc_vld = 1'($urandom); alloc_tid = TW'($urandom);
         free_vld = 1'($urandom); free_tid = TW'($urandom);
         squash_vld = (($urandom % 4) == 0); squash_tid = TW'($urandom);
         if (($urandom % 16) == 0) begin
            policy_sel = 2'($urandom); thresh_pct = PW'($urandom); cfg_load = 1;
         end
         if (($urandom % 16) == 0) begin active_mask = NT'($urandom); act_upd = 1; end
         cyc("R10");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule